// File: doc/BRIEF.md
# Framed Codec Serial Port

This block is the digital serial port of a two-way codec. It talks to a DSP host over a synchronous serial link and is the clock master of that link. It divides its master clock down to a serial bit clock. It sends 16-bit words MSB first, and each word is announced by a one-period frame pulse. Words from the host arrive on a separate data line, announced by their own frame pulse. The top bit of every received word marks it as data or as control. Data words go straight to the converter side. Control words write or read a bank of five 8-bit configuration registers.

An enable input gates the whole port. While the enable is low, the serial clock stops, the output pins float and the inputs are ignored. The configuration and pending words are kept, but the bit and frame counters restart when the enable returns. Several devices can share one host port in cascade: a control word meant for another device is passed on unchanged in the following output frame. The converter side delivers samples to the port through a strobe. Each sample goes out as a data word with the flag bit clear.

Top module: `codec_sport`

## Requirements
- R1: The serial clock period is (m+1)·2^(s+1) master clocks, with s = register A bits [1:0] and m = register A bits [3:2]. It is high for the first half of each period and low for the second half, and after reset the period is 2 master clocks.
- R2: An output frame raises fs_out for exactly one serial period on a rising serial edge. The 16 word bits follow on sdata_out, MSB first, each changing on a rising edge. sdata_oe is high only during those 16 bit periods.
- R3: fs_in and sdata_in are sampled on falling serial edges. A sampled fs_in high makes the next 16 falling edges capture one word, MSB first.
- R4: A received word with bit 15 = 0 is data: dac_word takes bits [14:0] and dac_valid pulses for exactly one master clock.
- R5: A control word (bit 15 = 1) is laid out as bit 14 read(1)/write(0), bits [13:11] device number, bits [10:8] register index (0..4 for registers A..E) and bits [7:0] value. A write stores the value in the indexed register, and a write to index 5..7 changes nothing.
- R6: A control read is answered by the next output frame with the word {1, 1, device, index, register value}. An index of 5..7 answers with value 0.
- R7: A word that has to be sent because of a received word (a read answer or a forwarded word) raises fs_out on the first rising serial edge after the last input bit is captured.
- R8: A pulse on smp_strobe queues the word {0, smp_word}. When a control answer and a sample are both waiting, the control answer goes first.
- R9: With register A bit 4 set (cascade), a control word whose device number differs from DEV_ID is forwarded unchanged, with the timing of R7, and does not touch the registers. With bit 4 clear, every control word is accepted whatever its device number.
- R10: While enable is low, sclk_out stays low, sdata_oe and fs_oe are low and the inputs have no effect. After enable returns, the registers still hold their earlier values and a new frame exchange works from scratch.
- R11: Reset clears all registers to 0 and holds sdata_oe and fs_oe low until the first output frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Port enable; low stops the clock and floats outputs |
| sdata_in | input | 1 | Serial data from host |
| fs_in | input | 1 | Input frame pulse from host |
| sclk_out | output | 1 | Serial bit clock to host |
| sdata_out | output | 1 | Serial data to host |
| sdata_oe | output | 1 | Drive enable for sdata_out (low = high impedance) |
| fs_out | output | 1 | Output frame pulse |
| fs_oe | output | 1 | Drive enable for fs_out (low = high impedance) |
| smp_strobe | input | 1 | Queue a sample for sending |
| smp_word | input | 15 | Sample value to send |
| dac_word | output | 15 | Last received data word |
| dac_valid | output | 1 | One-clock pulse when dac_word is updated |

## Verification
A wrong divider count shows up within one serial period as a changed sclk_out period or duty. A slip in the receive bit counter corrupts the next control word, and the answer frame then carries a shifted field or arrives late. A corrupted register only shows when it is read back, so every register is written and then read through the port. A wrong pending-word priority shows in the order of the output frames. A missed counter reset on the enable shows as a broken exchange right after the enable returns.

// File: rtl/codec_sport.sv
module codec_sport #(
  parameter int W      = 16,
  parameter int NREG   = 5,
  parameter int RW     = 8,
  parameter int DEV_ID = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         sdata_in,
  input  logic         fs_in,
  output logic         sclk_out,
  output logic         sdata_out,
  output logic         sdata_oe,
  output logic         fs_out,
  output logic         fs_oe,
  input  logic         smp_strobe,
  input  logic [W-2:0] smp_word,
  output logic [W-2:0] dac_word,
  output logic         dac_valid
);
  localparam int CW = $clog2(W + 1);
  localparam int DW = 8;

  logic [NREG-1:0][RW-1:0] regs;
  logic [DW-1:0] div_n, half_n, cnt;
  logic sclk_q, rise, fall;

  assign div_n  = ({6'd0, regs[0][3:2]} + 8'd1) << ({1'b0, regs[0][1:0]} + 3'd1);
  assign half_n = div_n >> 1;
  assign rise   = enable && (cnt == div_n - 8'd1);
  assign fall   = enable && (cnt == half_n - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt <= (cnt >= div_n - 8'd1) ? '0 : cnt + 8'd1;
      if (rise)      sclk_q <= 1'b1;
      else if (fall) sclk_q <= 1'b0;
    end
  end
  assign sclk_out = sclk_q & enable;

  logic [CW-1:0] rx_cnt;
  logic [W-1:0]  rx_sh, rx_word;
  logic          rx_done, is_ctl, is_rd, mine;
  logic [2:0]    dev, ra;
  logic [RW-1:0] rd_val;

  assign rx_word = {rx_sh[W-2:0], sdata_in};
  assign rx_done = fall && (rx_cnt == CW'(1));
  assign is_ctl  = rx_word[W-1];
  assign is_rd   = rx_word[W-2];
  assign dev     = rx_word[W-3:W-5];
  assign ra      = rx_word[W-6:W-8];
  assign mine    = !regs[0][4] || (dev == 3'(DEV_ID));

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (ra == 3'(i)) rd_val = regs[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      rx_cnt <= '0;
      rx_sh  <= '0;
    end else if (fall) begin
      if (rx_cnt != '0) begin
        rx_sh  <= rx_word;
        rx_cnt <= rx_cnt - CW'(1);
      end else if (fs_in) begin
        rx_cnt <= CW'(W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (rx_done && is_ctl && mine && !is_rd) begin
      for (int i = 0; i < NREG; i++)
        if (ra == 3'(i)) regs[i] <= rx_word[RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_word  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= rx_done && !is_ctl;
      if (rx_done && !is_ctl) dac_word <= rx_word[W-2:0];
    end
  end

  logic [W-1:0]  cpend, tx_sh;
  logic [W-2:0]  dpend;
  logic          cpv, dpv, start, sfo_q, tx_on, started, sdo_q;
  logic [CW-1:0] tx_cnt;

  assign start = rise && !sfo_q && !(tx_on && tx_cnt != '0) && (cpv || dpv);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpv   <= 1'b0;
      cpend <= '0;
      dpv   <= 1'b0;
      dpend <= '0;
    end else begin
      if (rx_done && is_ctl && mine && is_rd) begin
        cpv   <= 1'b1;
        cpend <= {rx_word[W-1:RW], rd_val};
      end else if (rx_done && is_ctl && !mine) begin
        cpv   <= 1'b1;
        cpend <= rx_word;
      end else if (start && cpv) begin
        cpv <= 1'b0;
      end
      if (smp_strobe) begin
        dpv   <= 1'b1;
        dpend <= smp_word;
      end else if (start && !cpv) begin
        dpv <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfo_q   <= 1'b0;
      tx_on   <= 1'b0;
      tx_cnt  <= '0;
      tx_sh   <= '0;
      sdo_q   <= 1'b0;
      started <= 1'b0;
    end else if (!enable) begin
      sfo_q  <= 1'b0;
      tx_on  <= 1'b0;
      tx_cnt <= '0;
    end else if (rise) begin
      if (sfo_q) begin
        sfo_q  <= 1'b0;
        tx_on  <= 1'b1;
        sdo_q  <= tx_sh[W-1];
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
        tx_cnt <= CW'(W - 1);
      end else if (tx_on && tx_cnt != '0) begin
        sdo_q  <= tx_sh[W-1];
        tx_sh  <= {tx_sh[W-2:0], 1'b0};
        tx_cnt <= tx_cnt - CW'(1);
      end else begin
        tx_on <= 1'b0;
        if (start) begin
          sfo_q   <= 1'b1;
          started <= 1'b1;
          tx_sh   <= cpv ? cpend : {1'b0, dpend};
        end
      end
    end
  end

  assign sdata_out = sdo_q;
  assign sdata_oe  = enable & tx_on;
  assign fs_out    = sfo_q;
  assign fs_oe     = enable & started;

  AST_SYNC_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sfo_q) |=> !sfo_q);  // R2
  AST_DRIVE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && sfo_q) |=> tx_on);  // R2
  AST_TX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(W - 1));  // R2
  AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(W));  // R3
  AST_DAC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);  // R4
  AST_BAD_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && is_ctl && !is_rd && ra >= 3'(NREG)) |=> $stable(regs));  // R5
  AST_READ_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && is_ctl && mine && is_rd) |=> cpv);  // R6
  AST_CLOCK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sclk_q);  // R10
endmodule

// File: tb/codec_sport_test.sv
module codec_sport_test;
  logic clk = 0, rst_n = 0, enable = 1, sdata_in = 0, fs_in = 0, smp_strobe = 0;
  logic [14:0] smp_word = '0;
  logic sclk_out, sdata_out, sdata_oe, fs_out, fs_oe, dac_valid;
  logic [14:0] dac_word;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  codec_sport uut (.clk(clk), .rst_n(rst_n), .enable(enable), .sdata_in(sdata_in),
    .fs_in(fs_in), .sclk_out(sclk_out), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .fs_out(fs_out), .fs_oe(fs_oe), .smp_strobe(smp_strobe), .smp_word(smp_word),
    .dac_word(dac_word), .dac_valid(dac_valid));

  logic [15:0] got [0:63];
  int got_n = 0, rd_idx = 0, mon_left = 0, dac_cnt = 0;
  logic [15:0] mon_sh;
  logic sclk_prev = 0;

  always @(negedge clk) begin
    if (dac_valid) dac_cnt++;
    if (!rst_n || !enable) mon_left = 0;
    else if (sclk_prev && !sclk_out) begin
      if (mon_left > 0) begin
        mon_sh = {mon_sh[14:0], sdata_oe ? sdata_out : 1'bx};
        mon_left--;
        if (mon_left == 0 && got_n < 64) begin got[got_n] = mon_sh; got_n++; end
      end else if (fs_out && fs_oe) mon_left = 16;
    end
    sclk_prev = sclk_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = sclk_out;
    forever begin
      @(negedge clk);
      if (sclk_out && !p) break;
      p = sclk_out;
    end
  endtask

  task automatic send(input logic [15:0] w);
    fs_in = 1;
    wait_rise();
    fs_in = 0;
    for (int i = 15; i >= 0; i--) begin sdata_in = w[i]; wait_rise(); end
    sdata_in = 0;
  endtask

  task automatic expect_word(input string tag, input logic [15:0] exp);
    int t;
    t = 0;
    while (got_n <= rd_idx && t < 3000) begin @(negedge clk); t++; end
    if (got_n <= rd_idx) begin
      checks++; errors++;
      $display("FAIL %s actual=none expected=%h", tag, exp);
    end else begin
      chk(tag, 32'(got[rd_idx]), 32'(exp));
      rd_idx++;
    end
  endtask

  task automatic measure(output int n, output int h);
    logic p;
    wait_rise();
    n = 0; h = 0; p = 1;
    forever begin
      @(negedge clk);
      n++;
      if (sclk_out) h++;
      if (sclk_out && !p) break;
      p = sclk_out;
    end
  endtask

  // {answer expected, word sent, answer}
  localparam logic [32:0] VEC [0:11] = '{
    {1'b1, 16'hC000, 16'hC000},  // R11 A cleared by reset
    {1'b0, 16'h815A, 16'h0000},  // R5 write B
    {1'b0, 16'h82C3, 16'h0000},  // R5 write C
    {1'b0, 16'h8301, 16'h0000},  // R5 write D
    {1'b0, 16'h84FF, 16'h0000},  // R5 write E
    {1'b0, 16'h8577, 16'h0000},  // R5 write index 5 ignored
    {1'b1, 16'hC100, 16'hC15A},  // R6 read B
    {1'b1, 16'hC200, 16'hC2C3},  // R6 read C
    {1'b1, 16'hC300, 16'hC301},  // R6 read D
    {1'b1, 16'hC400, 16'hC4FF},  // R6 read E
    {1'b1, 16'hC500, 16'hC500},  // R6 index 5 reads 0
    {1'b1, 16'hD900, 16'hD95A}   // R9 cascade off: any device accepted
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, h, d0;
    repeat (4) @(negedge clk);
    chk("R11 reset sdata_oe", 32'(sdata_oe), 0);
    chk("R11 reset fs_oe", 32'(fs_oe), 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk("R11 fs_oe before first frame", 32'(fs_oe), 0);
    measure(n, h);
    chk("R1 reset period", 32'(n), 2);
    chk("R1 reset high time", 32'(h), 1);

    wait_rise();
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][31:16]);
      if (VEC[i][32]) begin
        chk("R7 answer sync timing", 32'(fs_out && fs_oe), 1);
        expect_word("R6 answer word", VEC[i][15:0]);
      end
    end
    repeat (40) @(negedge clk);
    chk("R2 idle sdata_oe", 32'(sdata_oe), 0);
    chk("R3 no stray words", 32'(got_n), 32'(rd_idx));

    d0 = dac_cnt;
    wait_rise();
    send(16'h1234);
    repeat (4) @(negedge clk);
    chk("R4 dac_word", 32'(dac_word), 32'h1234);
    chk("R4 dac_valid one pulse", 32'(dac_cnt - d0), 1);

    wait_rise();
    send(16'hC100);
    smp_word = 15'h4321;
    smp_strobe = 1;
    send(16'hC200);
    smp_strobe = 0;
    expect_word("R8 first answer", 16'hC15A);
    expect_word("R8 second answer before sample", 16'hC2C3);
    expect_word("R8 sample word", 16'h4321);

    wait_rise();
    send(16'h800D);
    measure(n, h);
    chk("R1 divided period", 32'(n), 16);
    chk("R1 divided high time", 32'(h), 8);
    wait_rise();
    send(16'hC000);
    expect_word("R5 read A", 16'hC00D);
    wait_rise();
    send(16'h8010);
    measure(n, h);
    chk("R1 period back to 2", 32'(n), 2);

    wait_rise();
    send(16'h9199);
    chk("R9 forward sync timing", 32'(fs_out && fs_oe), 1);
    expect_word("R9 forwarded write", 16'h9199);
    wait_rise();
    send(16'hC100);
    expect_word("R9 B untouched", 16'hC15A);
    wait_rise();
    send(16'hE800);
    expect_word("R9 forwarded read", 16'hE800);

    wait_rise();
    send(16'hC200);
    repeat (3) wait_rise();
    enable = 0;
    @(negedge clk);
    chk("R10 sdata_oe off", 32'(sdata_oe), 0);
    chk("R10 fs_oe off", 32'(fs_oe), 0);
    for (int i = 0; i < 20; i++) begin
      fs_in = i[0];
      sdata_in = i[1];
      @(negedge clk);
      if (sclk_out !== 1'b0) chk("R10 clock stopped", 32'(sclk_out), 0);
    end
    chk("R10 clock stopped", 32'(sclk_out), 0);
    fs_in = 0; sdata_in = 0;
    rd_idx = got_n;
    enable = 1;
    wait_rise();
    send(16'hC200);
    expect_word("R10 C retained", 16'hC2C3);
    wait_rise();
    send(16'hC000);
    expect_word("R10 A retained", 16'hC010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule